// File: doc/BRIEF.md
# Flash command write sequencer

This block sits between the CPU bus and a flash back-end. Software forms a flash operation in three bus writes. First it writes an aligned word into the array window, which captures the address and the data. Then it writes an operation code into the command register. Finally it writes a one to the buffer-empty bit of the status register, which launches the operation. The block checks that the three steps arrive in order. It keeps the status flags and hands a masked command, address and data tuple to the back-end through a start/done handshake.

After an ordinary launch the capture buffers are free again a fixed number of cycles later. Software can therefore stage the next operation while the back-end is still working. That next operation waits in a one-entry issue slot. Two operation types keep the buffers busy until the back-end finishes them: the read-back compress and the sector-erase abort.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status byte reads 0xC0 and no start is issued. Status bits: bit 7 buffer-empty, bit 6 command-complete, bit 5 protection-violation, bit 4 access-error. The array window is bus address bit 15 = 1. Status is at register address 0x0000 and the command register at 0x0002.
- R2: An array write with byte address bit 0 = 1 is misaligned. It sets access-error and captures nothing.
- R3: A command write sets access-error and allows no launch if no array write came first, or if the code is not one of 0x05 verify, 0x06 compress, 0x20 program, 0x40 sector erase, 0x41 mass erase, 0x47 sector-erase abort.
- R4: A launch clears buffer-empty and command-complete at the launch edge. The tuple appears on the start port while the back-end is idle.
- R5: For ordinary codes, buffer-empty sets 4 cycles after the launch edge. If the issue slot is still occupied, it sets on the edge after that entry is handed to the back-end.
- R6: For codes 0x06 and 0x47, buffer-empty stays clear until the back-end reports done for that command.
- R7: Writing status with bit 7 = 0 after a valid command write aborts the sequence, sets access-error and issues nothing.
- R8: Any write between two steps breaks the sequence and sets access-error. Reads between steps have no effect.
- R9: An array write while buffer-empty is clear sets buffer-empty at once and replaces the buffers. A queued command that has not yet started is dropped.
- R10: Access-error and protection-violation clear by writing 1. A launch write is ignored while either flag was set before the write.
- R11: A command write with prot_i high and code 0x20, 0x40 or 0x41 sets protection-violation and allows no launch.
- R12: Command-complete sets when the back-end reports done and nothing is queued. A queued command starts in the cycle after the running one finishes.
- R13: The start tuple passes address and data for program and compress. For sector erase it zeroes address bits [9:0] and the data. For verify, mass erase and abort it zeroes both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Bus write strobe, one cycle per write |
| bus_addr_i | input | 16 | Bus byte address; bit 15 selects the array window |
| bus_wdata_i | input | 16 | Bus write data |
| bus_rdata_o | output | 16 | Read data for the addressed register (0 for the array window) |
| prot_i | input | 1 | Target region is protected |
| op_start_o | output | 1 | Start of a back-end operation |
| op_cmd_o | output | 8 | Operation code for the back-end |
| op_addr_o | output | 15 | Masked array byte address |
| op_data_o | output | 16 | Masked data word |
| op_done_i | input | 1 | One-cycle completion pulse from the back-end |

## Verification
The assertions assume that op_done_i pulses for exactly one cycle, and only while a started command is running. They also assume one bus write per cycle, with prot_i steady around a command write. The bench models the back-end by hand, so each done pulse follows a start seen earlier. Every bus access is driven on the falling edge and lasts exactly one cycle, so each launch edge is known and the buffer-empty timing can be counted exactly.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HAVE_DATA = 2'd1,
    SEQ_HAVE_CMD = 2'd2
  } seq_st_e;

  localparam int ST_BE   = 7;
  localparam int ST_DONE = 6;
  localparam int ST_PV   = 5;
  localparam int ST_ACC  = 4;

  localparam logic [7:0] OP_VERIFY   = 8'h05;
  localparam logic [7:0] OP_COMPRESS = 8'h06;
  localparam logic [7:0] OP_PROGRAM  = 8'h20;
  localparam logic [7:0] OP_SECT_ER  = 8'h40;
  localparam logic [7:0] OP_MASS_ER  = 8'h41;
  localparam logic [7:0] OP_ABORT    = 8'h47;

  function automatic logic op_known(input logic [7:0] c);
    return (c == OP_VERIFY) || (c == OP_COMPRESS) || (c == OP_PROGRAM) ||
           (c == OP_SECT_ER) || (c == OP_MASS_ER) || (c == OP_ABORT);
  endfunction

  function automatic logic op_long(input logic [7:0] c);
    return (c == OP_COMPRESS) || (c == OP_ABORT);
  endfunction

  function automatic logic op_modifies(input logic [7:0] c);
    return (c == OP_PROGRAM) || (c == OP_SECT_ER) || (c == OP_MASS_ER);
  endfunction
endpackage

// File: rtl/fcs_bus_decode.sv
module fcs_bus_decode #(
  parameter int AW = 16
) (
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic          arr_wr_o,
  output logic          arr_mis_o,
  output logic          st_wr_o,
  output logic          cmd_wr_o,
  output logic [AW-2:0] arr_off_o
);
  logic arr_sel;
  assign arr_sel   = addr_i[AW-1];
  assign arr_wr_o  = we_i & arr_sel & ~addr_i[0];
  assign arr_mis_o = we_i & arr_sel & addr_i[0];
  assign st_wr_o   = we_i & ~arr_sel & ~addr_i[1];
  assign cmd_wr_o  = we_i & ~arr_sel & addr_i[1];
  assign arr_off_o = addr_i[AW-2:0];
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BE_DELAY  = 4,
  parameter int SECT_BITS = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arr_wr_i,
  input  logic          arr_mis_i,
  input  logic          st_wr_i,
  input  logic          cmd_wr_i,
  input  logic [AW-2:0] arr_off_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          prot_i,
  input  logic          q_busy_i,
  input  logic          fin_i,
  input  logic          fin_long_i,
  output logic          be_o,
  output logic          done_o,
  output logic          acc_o,
  output logic          pv_o,
  output logic [7:0]    cmd_o,
  output logic          launch_o,
  output logic [7:0]    l_cmd_o,
  output logic [AW-2:0] l_addr_o,
  output logic [DW-1:0] l_data_o,
  output logic          l_long_o,
  output logic          cancel_o
);
  localparam int AAW = AW - 1;
  localparam int CW  = $clog2(BE_DELAY + 1);

  seq_st_e       st_q, st_n;
  logic          be_q, done_q, acc_q, pv_q, wait_ord_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    cmd_q;
  logic [AAW-1:0] adr_q;
  logic [DW-1:0] dat_q;
  logic          set_acc, set_pv, latch, cmd_ld;

  assign launch_o = st_wr_i & wdata_i[ST_BE] & (st_q == SEQ_HAVE_CMD) & ~acc_q & ~pv_q;
  assign cancel_o = arr_wr_i & ~be_q;

  always_comb begin
    set_acc = 1'b0;
    set_pv  = 1'b0;
    latch   = 1'b0;
    cmd_ld  = 1'b0;
    st_n    = st_q;
    if (arr_mis_i) begin
      set_acc = 1'b1;
      st_n    = SEQ_IDLE;
    end else if (arr_wr_i) begin
      if (st_q == SEQ_IDLE) begin
        latch = 1'b1;
        st_n  = SEQ_HAVE_DATA;
      end else begin
        set_acc = 1'b1;
        st_n    = SEQ_IDLE;
      end
    end else if (cmd_wr_i) begin
      if (st_q != SEQ_HAVE_DATA || !op_known(wdata_i[7:0])) begin
        set_acc = 1'b1;
        st_n    = SEQ_IDLE;
      end else if (prot_i && op_modifies(wdata_i[7:0])) begin
        set_pv = 1'b1;
        st_n   = SEQ_IDLE;
      end else begin
        cmd_ld = 1'b1;
        st_n   = SEQ_HAVE_CMD;
      end
    end else if (st_wr_i) begin
      unique case (st_q)
        SEQ_HAVE_DATA: begin
          set_acc = 1'b1;
          st_n    = SEQ_IDLE;
        end
        SEQ_HAVE_CMD: begin
          if (!wdata_i[ST_BE]) begin
            set_acc = 1'b1;
            st_n    = SEQ_IDLE;
          end else if (launch_o) begin
            st_n = SEQ_IDLE;
          end
        end
        default: set_acc = wdata_i[ST_BE];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      acc_q <= 1'b0;
      pv_q  <= 1'b0;
      cmd_q <= '0;
      adr_q <= '0;
      dat_q <= '0;
    end else begin
      st_q  <= st_n;
      acc_q <= (acc_q & ~(st_wr_i & wdata_i[ST_ACC])) | set_acc;
      pv_q  <= (pv_q & ~(st_wr_i & wdata_i[ST_PV])) | set_pv;
      if (cmd_ld) cmd_q <= wdata_i[7:0];
      if (latch) begin
        adr_q <= arr_off_i;
        dat_q <= wdata_i;
      end
    end
  end

  // buffer-empty / complete timing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_q       <= 1'b1;
      done_q     <= 1'b1;
      wait_ord_q <= 1'b0;
      cnt_q      <= '0;
    end else if (launch_o) begin
      be_q       <= 1'b0;
      done_q     <= 1'b0;
      wait_ord_q <= ~op_long(cmd_q);
      cnt_q      <= CW'(BE_DELAY);
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (arr_wr_i && !be_q) begin
        be_q       <= 1'b1;
        wait_ord_q <= 1'b0;
      end else if (wait_ord_q && cnt_q <= CW'(1) && !q_busy_i) begin
        be_q       <= 1'b1;
        wait_ord_q <= 1'b0;
      end else if (fin_long_i && !wait_ord_q) begin
        be_q <= 1'b1;
      end
      if (fin_i) done_q <= 1'b1;
    end
  end

  always_comb begin
    l_addr_o = '0;
    l_data_o = '0;
    unique case (cmd_q)
      OP_PROGRAM, OP_COMPRESS: begin
        l_addr_o = adr_q;
        l_data_o = dat_q;
      end
      OP_SECT_ER: l_addr_o = {adr_q[AAW-1:SECT_BITS], {SECT_BITS{1'b0}}};
      default: ;
    endcase
  end

  assign l_cmd_o  = cmd_q;
  assign l_long_o = op_long(cmd_q);
  assign be_o     = be_q;
  assign done_o   = done_q;
  assign acc_o    = acc_q;
  assign pv_o     = pv_q;
  assign cmd_o    = cmd_q;

  assert_launch_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> (!be_q && !done_q));
  assert_cmd_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && st_q != SEQ_HAVE_DATA) |=> acc_q);
  assert_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_HAVE_CMD && st_wr_i && !wdata_i[ST_BE]) |=> (acc_q && st_q == SEQ_IDLE));
  assert_blocked_launch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr_i && wdata_i[ST_BE] && be_q && (acc_q || pv_q)) |=> be_q);
  assert_long_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!be_q && !wait_ord_q && !arr_wr_i && !fin_long_i) |=> !be_q);
endmodule

// File: rtl/fcs_issue.sv
module fcs_issue #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [7:0]    l_cmd_i,
  input  logic [AW-2:0] l_addr_i,
  input  logic [DW-1:0] l_data_i,
  input  logic          l_long_i,
  input  logic          cancel_i,
  input  logic          done_i,
  output logic          start_o,
  output logic [7:0]    cmd_o,
  output logic [AW-2:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          q_valid_o,
  output logic          fin_o,
  output logic          fin_long_o
);
  logic q_valid_q, q_long_q, busy_q, run_long_q;

  assign start_o    = q_valid_q & ~busy_q;
  assign q_valid_o  = q_valid_q;
  assign fin_o      = done_i & busy_q & ~q_valid_q;
  assign fin_long_o = done_i & busy_q & run_long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_valid_q  <= 1'b0;
      q_long_q   <= 1'b0;
      busy_q     <= 1'b0;
      run_long_q <= 1'b0;
      cmd_o      <= '0;
      addr_o     <= '0;
      data_o     <= '0;
    end else begin
      if (launch_i) begin
        q_valid_q <= 1'b1;
        q_long_q  <= l_long_i;
        cmd_o     <= l_cmd_i;
        addr_o    <= l_addr_i;
        data_o    <= l_data_i;
      end else if (start_o || cancel_i) begin
        q_valid_q <= 1'b0;
      end
      if (start_o) begin
        busy_q     <= 1'b1;
        run_long_q <= q_long_q;
      end else if (done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assert_slot_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !q_valid_q);
  assert_queue_next_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy_q && q_valid_q && !cancel_i) |=> start_o);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BE_DELAY  = 4,
  parameter int SECT_BITS = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          prot_i,
  output logic          op_start_o,
  output logic [7:0]    op_cmd_o,
  output logic [AW-2:0] op_addr_o,
  output logic [DW-1:0] op_data_o,
  input  logic          op_done_i
);
  logic          arr_wr, arr_mis, st_wr, cmd_wr;
  logic [AW-2:0] arr_off;
  logic          be, done, acc, pv, launch, l_long, cancel;
  logic          q_valid, fin, fin_long;
  logic [7:0]    cmd_reg, l_cmd;
  logic [AW-2:0] l_addr;
  logic [DW-1:0] l_data;

  fcs_bus_decode #(.AW(AW)) u_dec (
    .we_i(bus_we_i), .addr_i(bus_addr_i), .arr_wr_o(arr_wr), .arr_mis_o(arr_mis),
    .st_wr_o(st_wr), .cmd_wr_o(cmd_wr), .arr_off_o(arr_off)
  );

  fcs_seq #(.AW(AW), .DW(DW), .BE_DELAY(BE_DELAY), .SECT_BITS(SECT_BITS)) u_seq (
    .clk_i, .rst_ni, .arr_wr_i(arr_wr), .arr_mis_i(arr_mis), .st_wr_i(st_wr),
    .cmd_wr_i(cmd_wr), .arr_off_i(arr_off), .wdata_i(bus_wdata_i), .prot_i,
    .q_busy_i(q_valid), .fin_i(fin), .fin_long_i(fin_long), .be_o(be),
    .done_o(done), .acc_o(acc), .pv_o(pv), .cmd_o(cmd_reg), .launch_o(launch),
    .l_cmd_o(l_cmd), .l_addr_o(l_addr), .l_data_o(l_data), .l_long_o(l_long),
    .cancel_o(cancel)
  );

  fcs_issue #(.AW(AW), .DW(DW)) u_iss (
    .clk_i, .rst_ni, .launch_i(launch), .l_cmd_i(l_cmd), .l_addr_i(l_addr),
    .l_data_i(l_data), .l_long_i(l_long), .cancel_i(cancel), .done_i(op_done_i),
    .start_o(op_start_o), .cmd_o(op_cmd_o), .addr_o(op_addr_o), .data_o(op_data_o),
    .q_valid_o(q_valid), .fin_o(fin), .fin_long_o(fin_long)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (!bus_addr_i[AW-1]) begin
      if (bus_addr_i[1]) bus_rdata_o = {{(DW-8){1'b0}}, cmd_reg};
      else               bus_rdata_o = {{(DW-8){1'b0}}, be, done, pv, acc, 4'b0000};
    end
  end
endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam logic [15:0] STAT = 16'h0000;
  localparam logic [15:0] CMDR = 16'h0002;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, prot = 1'b0, done_in = 1'b0;
  logic [15:0] addr = '0, wdata = '0, rdata;
  logic start;
  logic [7:0] op_cmd;
  logic [14:0] op_addr;
  logic [15:0] op_data;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .prot_i(prot),
    .op_start_o(start), .op_cmd_o(op_cmd), .op_addr_o(op_addr),
    .op_data_o(op_data), .op_done_i(done_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [15:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic stat(input string tag, input logic [7:0] exp);
    addr = STAT; #1;
    chk(tag, rdata, {8'h00, exp});
  endtask

  task automatic st_chk(input string tag, input logic [7:0] c, input logic [14:0] a,
                        input logic [15:0] d);
    chk({tag, " start"}, start, 1'b1);
    chk({tag, " cmd"}, op_cmd, c);
    chk({tag, " addr"}, op_addr, a);
    chk({tag, " data"}, op_data, d);
  endtask

  task automatic pulse_done();
    done_in = 1'b1;
    @(negedge clk);
    done_in = 1'b0;
  endtask

  task automatic t_reset();
    stat("R1 reset status", 8'hC0);
    chk("R1 no start", start, 1'b0);
  endtask

  task automatic t_program();
    bwr(16'h8124, 16'hBEEF); bwr(CMDR, 16'h0020); bwr(STAT, 16'h0080);
    st_chk("R4 program tuple", 8'h20, 15'h0124, 16'hBEEF);
    stat("R4 launch clears", 8'h00);
    tick(3); stat("R5 be still clear", 8'h00);
    tick(1); stat("R5 be after 4", 8'h80);
    pulse_done(); stat("R12 complete", 8'hC0);
  endtask

  task automatic t_sector();
    bwr(16'h87FE, 16'h5555); bwr(CMDR, 16'h0040); bwr(STAT, 16'h0080);
    st_chk("R13 sector mask", 8'h40, 15'h0400, 16'h0000);
    tick(4); stat("R5 sector be", 8'h80);
    pulse_done(); stat("R12 sector done", 8'hC0);
  endtask

  task automatic t_long(input logic [7:0] c, input logic [14:0] ea, input logic [15:0] ed);
    bwr(16'h8010, 16'h0005); bwr(CMDR, {8'h00, c}); bwr(STAT, 16'h0080);
    st_chk("R13 long tuple", c, ea, ed);
    tick(10); stat("R6 be held", 8'h00);
    pulse_done(); stat("R6 be on done", 8'hC0);
  endtask

  task automatic t_zeroed();
    bwr(16'h8ABC, 16'h1111); bwr(CMDR, 16'h0041); bwr(STAT, 16'h0080);
    st_chk("R13 mass zero", 8'h41, 15'h0000, 16'h0000);
    tick(4); pulse_done(); stat("R12 mass done", 8'hC0);
  endtask

  task automatic t_cmd_errors();
    bwr(CMDR, 16'h0020); stat("R3 cmd no data", 8'hD0);
    bwr(STAT, 16'h0080); tick(1);
    chk("R3 no launch", start, 1'b0); stat("R3 be kept", 8'hD0);
    bwr(STAT, 16'h0010); stat("R10 w1c acc", 8'hC0);
    bwr(16'h8100, 16'h0001); bwr(CMDR, 16'h0033); stat("R3 bad code", 8'hD0);
    bwr(STAT, 16'h0080); chk("R3 bad code no start", start, 1'b0);
    bwr(STAT, 16'h0010); stat("R3 cleared", 8'hC0);
  endtask

  task automatic t_abort();
    bwr(16'h8100, 16'h0002); bwr(CMDR, 16'h0020); bwr(STAT, 16'h0000);
    stat("R7 abort acc", 8'hD0); tick(2);
    chk("R7 nothing issued", start, 1'b0);
    bwr(STAT, 16'h0080); chk("R7 no late launch", start, 1'b0);
    bwr(STAT, 16'h0010); stat("R7 cleared", 8'hC0);
  endtask

  task automatic t_breaks();
    bwr(16'h8100, 16'h0002); bwr(STAT, 16'h0000); stat("R8 status write breaks", 8'hD0);
    bwr(STAT, 16'h0010);
    bwr(16'h8100, 16'h0002); bwr(CMDR, 16'h0020); bwr(16'h8200, 16'h0003);
    stat("R8 array write breaks", 8'hD0);
    bwr(STAT, 16'h0080); chk("R8 broken no start", start, 1'b0);
    bwr(STAT, 16'h0010);
    bwr(16'h8300, 16'h7777);
    stat("R8 read between", 8'hC0);
    addr = 16'h8300; #1; chk("R8 array read", rdata, 16'h0000);
    tick(1);
    bwr(CMDR, 16'h0005);
    addr = CMDR; #1; chk("R8 cmd readback", rdata, 16'h0005);
    stat("R8 read after cmd", 8'hC0);
    tick(1);
    bwr(STAT, 16'h0080);
    st_chk("R13 verify zero", 8'h05, 15'h0000, 16'h0000);
    tick(4); pulse_done(); stat("R8 done", 8'hC0);
  endtask

  task automatic t_misalign();
    bwr(16'h8125, 16'h4444); stat("R2 misaligned", 8'hD0);
    bwr(CMDR, 16'h0020); stat("R2 nothing captured", 8'hD0);
    bwr(STAT, 16'h0010); stat("R2 cleared", 8'hC0);
  endtask

  task automatic t_prot();
    prot = 1'b1;
    bwr(16'h8400, 16'h0009); bwr(CMDR, 16'h0040); stat("R11 pviol", 8'hE0);
    bwr(STAT, 16'h0080); chk("R11 no start", start, 1'b0);
    stat("R11 launch refused", 8'hF0);
    bwr(STAT, 16'h0030); stat("R10 w1c both", 8'hC0);
    prot = 1'b0;
  endtask

  task automatic t_blocked();
    bwr(CMDR, 16'h0020); stat("R10 acc set", 8'hD0);
    bwr(16'h8040, 16'h0001); bwr(CMDR, 16'h0020);
    bwr(STAT, 16'h0080); chk("R10 launch ignored", start, 1'b0);
    stat("R10 status kept", 8'hD0);
    bwr(STAT, 16'h0090); chk("R10 clear+launch ignored", start, 1'b0);
    stat("R10 cleared", 8'hC0);
    bwr(STAT, 16'h0080);
    st_chk("R10 launch after clear", 8'h20, 15'h0040, 16'h0001);
    tick(4); pulse_done(); stat("R10 done", 8'hC0);
  endtask

  task automatic t_queue();
    bwr(16'h8002, 16'hAAAA); bwr(CMDR, 16'h0020); bwr(STAT, 16'h0080);
    st_chk("R12 first", 8'h20, 15'h0002, 16'hAAAA);
    tick(4); stat("R5 be back", 8'h80);
    bwr(16'h8004, 16'hBBBB); bwr(CMDR, 16'h0020); bwr(STAT, 16'h0080);
    chk("R12 held while busy", start, 1'b0);
    tick(6); stat("R5 be held by slot", 8'h00);
    pulse_done();
    stat("R12 not complete yet", 8'h00);
    st_chk("R12 queued start", 8'h20, 15'h0004, 16'hBBBB);
    tick(1); stat("R5 handoff edge", 8'h00);
    tick(1); stat("R5 be after handoff", 8'h80);
    pulse_done(); stat("R12 all done", 8'hC0);
  endtask

  task automatic t_drop();
    bwr(16'h8006, 16'h0101); bwr(CMDR, 16'h0020); bwr(STAT, 16'h0080);
    tick(4);
    bwr(16'h8008, 16'h0202); bwr(CMDR, 16'h0020); bwr(STAT, 16'h0080);
    stat("R9 slot full", 8'h00);
    bwr(16'h800A, 16'h0303); stat("R9 be forced", 8'h80);
    chk("R9 no start", start, 1'b0);
    pulse_done(); chk("R9 dropped", start, 1'b0);
    stat("R9 complete", 8'hC0);
    bwr(CMDR, 16'h0020); bwr(STAT, 16'h0080);
    st_chk("R9 new buffers", 8'h20, 15'h000A, 16'h0303);
    tick(4); pulse_done(); stat("R9 done", 8'hC0);
  endtask

  task automatic t_overwrite_long();
    bwr(16'h8010, 16'h0008); bwr(CMDR, 16'h0006); bwr(STAT, 16'h0080);
    tick(8); stat("R6 compress busy", 8'h00);
    bwr(16'h8200, 16'h1234); stat("R9 overwrite sets be", 8'h80);
    pulse_done(); stat("R12 compress done", 8'hC0);
    bwr(CMDR, 16'h0020); bwr(STAT, 16'h0080);
    st_chk("R9 replaced buffers", 8'h20, 15'h0200, 16'h1234);
    tick(4); pulse_done(); stat("R9 prog done", 8'hC0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_program();
    t_sector();
    t_long(8'h06, 15'h0010, 16'h0005);
    t_long(8'h47, 15'h0000, 16'h0000);
    t_zeroed();
    t_cmd_errors();
    t_abort();
    t_breaks();
    t_misalign();
    t_prot();
    t_blocked();
    t_queue();
    t_drop();
    t_overwrite_long();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule